// File: doc/BRIEF.md
# Protection Trip Timestamper and Heartbeat Monitor

This block captures faults for a machine protection system that shares the accelerator timing link. It samples a vector of fault inputs once per link clock tick. A per-beam-mode enable table masks the vector. Every new trip is stamped with a time built from two counters: a cycle counter that advances at each cycle-start event, and a tick counter that restarts there. The resolution is therefore one link tick, about 63 ns. The block also keeps a frozen record of the first input to trip, so that a correlator can find the root fault among many later trips.

Two permit outputs act on downstream carriers. The self-recovering permit falls on any enabled fault and rises again at the next cycle start that sees no fault. The latched permit falls the same way but rises only when an operator reset pulse arrives on a tick that sees no fault. A watchdog counts ticks between cycle-start events. If the nominal 60 Hz heartbeat stops for longer than the limit, the watchdog raises a fault of its own. That fault takes part in trip recording and permit logic as one extra, always-enabled input. The heartbeat state and the active mode are driven out so that the timing system can see them.

Top module: `prot_trip_recorder`

## Requirements
- R1: Fault inputs, the cycle-start strobe and the latch reset are acted on only in cycles where `tick` is high. Fault levels present only between ticks produce no trip and no permit change.
- R2: `trip_stamp` is {cycle count, tick count}, with the cycle count in the upper CYC_W bits. It holds the counter values seen on the tick that sampled the trip. A tick with `cyc_start` clears the tick count and increments the cycle count. Every other tick increments the tick count, which saturates at its maximum.
- R3: On a tick where an enabled input (or the heartbeat fault) goes from clear to set, `trip_valid` pulses for one clock. In that clock `trip_bits` shows the newly set bits: bit i for fault input i, and bit N_IN for the heartbeat fault. A fault that stays set does not pulse again.
- R4: When no first-fault record is held, the first trip sets `first_valid`. It records in `first_idx` the lowest-numbered bit among those newly set on that tick, and records its stamp in `first_stamp`. Later trips leave the record unchanged. The record holds until a `first_clear` pulse, which takes effect with or without a tick.
- R5: `permit_auto` falls on any tick that samples an enabled fault. It rises again only on a cycle-start tick that samples no enabled fault.
- R6: `permit_latch` falls on any tick that samples an enabled fault. It rises only on a tick with `latch_rst` high and no enabled fault sampled.
- R7: Each mode has its own enable mask in a table of 2**MODE_W entries. The table is written through `mask_we`/`mask_addr`/`mask_wdata` and resets to all inputs enabled. A `mode_req` value becomes `active_mode` only on a cycle-start tick. Until then, the old mode's mask applies.
- R8: When WDOG_TICKS consecutive ticks pass without a cycle start, `hb_fault` is set on the last of them. The next tick then counts it as a trip on bit N_IN. `hb_fault` clears on the next cycle-start tick.
- R9: After reset, both permits are low, the counters are zero, `active_mode` is 0, and `first_valid`, `trip_valid` and `hb_fault` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock strobe per link clock tick |
| cyc_start | input | 1 | Cycle-start event, valid with tick |
| fault_in | input | N_IN | Raw fault levels, high = fault |
| mode_req | input | MODE_W | Requested beam mode |
| mask_we | input | 1 | Write enable for the mode mask table |
| mask_addr | input | MODE_W | Mode entry to write |
| mask_wdata | input | N_IN | Enable mask, high = input enabled |
| latch_rst | input | 1 | Rearm request for the latched permit |
| first_clear | input | 1 | Clears the first-fault record |
| permit_auto | output | 1 | Self-recovering permit |
| permit_latch | output | 1 | Latched permit |
| trip_valid | output | 1 | One-clock pulse on a new trip |
| trip_bits | output | N_IN+1 | Newly set fault bits of the last trip |
| trip_stamp | output | CYC_W+TICK_W | Time of the last trip |
| first_valid | output | 1 | A first-fault record is held |
| first_idx | output | IDX_W | Bit index of the first fault |
| first_stamp | output | CYC_W+TICK_W | Time of the first fault |
| hb_fault | output | 1 | Heartbeat missing |
| active_mode | output | MODE_W | Mode whose mask is applied |

## Verification
Single-bit, multi-bit and held fault patterns separate edge detection from level detection. The lowest-index rule is shown when two inputs assert together while the record is empty, and the frozen record is shown when a different input trips later. Fault pulses that fall between ticks must produce no trip. A masked input and an unmasked input, each asserted in a mode that changed at a cycle start, show that the mask is applied and that the mode switches only at cycle start. A long run of ticks with no cycle start exercises the watchdog and the two-cycle-start recovery of the self-resetting permit. Latch rearm attempts with and without a fault present show that only a clean tick rearms the latched permit.

// File: rtl/trip_pkg.sv
package trip_pkg;
  // Lowest set bit of a vector, or zero when empty.
  function automatic int unsigned lowest_set(input logic [63:0] v, input int unsigned w);
    int unsigned r;
    r = 0;
    for (int i = 63; i >= 0; i--) begin
      if (i < int'(w) && v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/trip_timebase.sv
module trip_timebase #(
  parameter int TICK_W     = 20,
  parameter int CYC_W      = 16,
  parameter int WDOG_TICKS = 317460
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cyc_start,
  output logic [TICK_W-1:0] tick_cnt,
  output logic [CYC_W-1:0]  cyc_cnt,
  output logic              hb_fault
);
  localparam int WD_W = $clog2(WDOG_TICKS + 1);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WDOG_TICKS - 1);

  logic [WD_W-1:0] wd_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
      cyc_cnt  <= '0;
      wd_cnt   <= '0;
      hb_fault <= 1'b0;
    end else if (tick) begin
      if (cyc_start) begin
        tick_cnt <= '0;
        cyc_cnt  <= cyc_cnt + 1'b1;
        wd_cnt   <= '0;
        hb_fault <= 1'b0;
      end else begin
        if (tick_cnt != '1) tick_cnt <= tick_cnt + 1'b1;
        if (wd_cnt == WD_LAST) hb_fault <= 1'b1;
        else                   wd_cnt   <= wd_cnt + 1'b1;
      end
    end
  end

  // R2
  tick_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cyc_start) |=> (tick_cnt == '0 && cyc_cnt == $past(cyc_cnt) + 1'b1));
  // R8
  hb_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hb_fault) |-> $past(tick && !cyc_start));
endmodule

// File: rtl/trip_mode_mask.sv
module trip_mode_mask #(
  parameter int N_IN   = 8,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cyc_start,
  input  logic [MODE_W-1:0] mode_req,
  input  logic              mask_we,
  input  logic [MODE_W-1:0] mask_addr,
  input  logic [N_IN-1:0]   mask_wdata,
  output logic [MODE_W-1:0] active_mode,
  output logic [N_IN-1:0]   mask_out
);
  localparam int N_MODES = 2 ** MODE_W;

  logic [N_IN-1:0] mask_tbl [N_MODES];

  for (genvar m = 0; m < N_MODES; m++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)                                    mask_tbl[m] <= '1;
      else if (mask_we && mask_addr == MODE_W'(m)) mask_tbl[m] <= mask_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    active_mode <= '0;
    else if (tick && cyc_start) active_mode <= mode_req;
  end

  assign mask_out = mask_tbl[active_mode];

  // R7
  mode_switch_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(active_mode) |-> $past(tick && cyc_start));
endmodule

// File: rtl/trip_first_capture.sv
module trip_first_capture
  import trip_pkg::*;
#(
  parameter int EFF_W   = 9,
  parameter int STAMP_W = 36,
  parameter int IDX_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic [EFF_W-1:0]   rising,
  input  logic [STAMP_W-1:0] stamp,
  input  logic               first_clear,
  output logic               first_valid,
  output logic [IDX_W-1:0]   first_idx,
  output logic [STAMP_W-1:0] first_stamp
);
  logic [IDX_W-1:0] low_idx;

  always_comb begin
    low_idx = IDX_W'(lowest_set(64'(rising), EFF_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_valid <= 1'b0;
      first_idx   <= '0;
      first_stamp <= '0;
    end else if (first_clear) begin
      first_valid <= 1'b0;
    end else if (tick && !first_valid && rising != '0) begin
      first_valid <= 1'b1;
      first_idx   <= low_idx;
      first_stamp <= stamp;
    end
  end

  // R4
  first_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (first_valid && !first_clear) |=> ($stable(first_idx) && $stable(first_stamp) && first_valid));
endmodule

// File: rtl/trip_permits.sv
module trip_permits (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cyc_start,
  input  logic latch_rst,
  input  logic any_fault,
  output logic permit_auto,
  output logic permit_latch
);
  always_ff @(posedge clk) begin
    if (rst) begin
      permit_auto  <= 1'b0;
      permit_latch <= 1'b0;
    end else if (tick) begin
      if (any_fault) begin
        permit_auto  <= 1'b0;
        permit_latch <= 1'b0;
      end else begin
        if (cyc_start) permit_auto  <= 1'b1;
        if (latch_rst) permit_latch <= 1'b1;
      end
    end
  end

  // R5
  auto_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(permit_auto) |-> $past(tick && cyc_start && !any_fault));
  // R6
  latch_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(permit_latch) |-> $past(tick && latch_rst && !any_fault));
endmodule

// File: rtl/prot_trip_recorder.sv
module prot_trip_recorder #(
  parameter int N_IN       = 8,
  parameter int MODE_W     = 3,
  parameter int TICK_W     = 20,
  parameter int CYC_W      = 16,
  parameter int WDOG_TICKS = 317460,
  localparam int EFF_W     = N_IN + 1,
  localparam int STAMP_W   = CYC_W + TICK_W,
  localparam int IDX_W     = $clog2(EFF_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               cyc_start,
  input  logic [N_IN-1:0]    fault_in,
  input  logic [MODE_W-1:0]  mode_req,
  input  logic               mask_we,
  input  logic [MODE_W-1:0]  mask_addr,
  input  logic [N_IN-1:0]    mask_wdata,
  input  logic               latch_rst,
  input  logic               first_clear,
  output logic               permit_auto,
  output logic               permit_latch,
  output logic               trip_valid,
  output logic [EFF_W-1:0]   trip_bits,
  output logic [STAMP_W-1:0] trip_stamp,
  output logic               first_valid,
  output logic [IDX_W-1:0]   first_idx,
  output logic [STAMP_W-1:0] first_stamp,
  output logic               hb_fault,
  output logic [MODE_W-1:0]  active_mode
);
  logic [TICK_W-1:0] tick_cnt;
  logic [CYC_W-1:0]  cyc_cnt;
  logic [N_IN-1:0]   mask_cur;
  logic [EFF_W-1:0]  eff, prev_q, rising;
  logic [STAMP_W-1:0] stamp;

  trip_timebase #(.TICK_W(TICK_W), .CYC_W(CYC_W), .WDOG_TICKS(WDOG_TICKS)) i_timebase (
    .clk(clk), .rst(rst), .tick(tick), .cyc_start(cyc_start),
    .tick_cnt(tick_cnt), .cyc_cnt(cyc_cnt), .hb_fault(hb_fault));

  trip_mode_mask #(.N_IN(N_IN), .MODE_W(MODE_W)) i_mask (
    .clk(clk), .rst(rst), .tick(tick), .cyc_start(cyc_start), .mode_req(mode_req),
    .mask_we(mask_we), .mask_addr(mask_addr), .mask_wdata(mask_wdata),
    .active_mode(active_mode), .mask_out(mask_cur));

  assign eff    = {hb_fault, fault_in & mask_cur};
  assign rising = eff & ~prev_q;
  assign stamp  = {cyc_cnt, tick_cnt};

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q     <= '0;
      trip_valid <= 1'b0;
      trip_bits  <= '0;
      trip_stamp <= '0;
    end else begin
      trip_valid <= 1'b0;
      if (tick) begin
        prev_q <= eff;
        if (rising != '0) begin
          trip_valid <= 1'b1;
          trip_bits  <= rising;
          trip_stamp <= stamp;
        end
      end
    end
  end

  trip_first_capture #(.EFF_W(EFF_W), .STAMP_W(STAMP_W), .IDX_W(IDX_W)) i_first (
    .clk(clk), .rst(rst), .tick(tick), .rising(rising), .stamp(stamp),
    .first_clear(first_clear), .first_valid(first_valid),
    .first_idx(first_idx), .first_stamp(first_stamp));

  trip_permits i_permits (
    .clk(clk), .rst(rst), .tick(tick), .cyc_start(cyc_start), .latch_rst(latch_rst),
    .any_fault(eff != '0), .permit_auto(permit_auto), .permit_latch(permit_latch));

  // R3
  trip_bits_chk: assert property (@(posedge clk) disable iff (rst)
    trip_valid |-> (trip_bits != '0 && $past(tick)));
  // R3
  trip_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    trip_valid |=> !trip_valid || $past(tick));
endmodule

// File: tb/test_prot_trip_recorder.sv
module test_prot_trip_recorder;
  localparam int N_IN = 4, MODE_W = 3, TICK_W = 8, CYC_W = 8, WDOG = 12;
  localparam int EFF_W = N_IN + 1, STAMP_W = CYC_W + TICK_W, IDX_W = $clog2(EFF_W);

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, cyc_start = 1'b0;
  logic [N_IN-1:0] fault_in = '0, mask_wdata = '0;
  logic [MODE_W-1:0] mode_req = '0, mask_addr = '0, active_mode;
  logic mask_we = 1'b0, latch_rst = 1'b0, first_clear = 1'b0;
  logic permit_auto, permit_latch, trip_valid, first_valid, hb_fault;
  logic [EFF_W-1:0] trip_bits;
  logic [STAMP_W-1:0] trip_stamp, first_stamp;
  logic [IDX_W-1:0] first_idx;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prot_trip_recorder #(.N_IN(N_IN), .MODE_W(MODE_W), .TICK_W(TICK_W), .CYC_W(CYC_W),
                       .WDOG_TICKS(WDOG)) i_prot_trip_recorder (
    .clk(clk), .rst(rst), .tick(tick), .cyc_start(cyc_start), .fault_in(fault_in),
    .mode_req(mode_req), .mask_we(mask_we), .mask_addr(mask_addr), .mask_wdata(mask_wdata),
    .latch_rst(latch_rst), .first_clear(first_clear), .permit_auto(permit_auto),
    .permit_latch(permit_latch), .trip_valid(trip_valid), .trip_bits(trip_bits),
    .trip_stamp(trip_stamp), .first_valid(first_valid), .first_idx(first_idx),
    .first_stamp(first_stamp), .hb_fault(hb_fault), .active_mode(active_mode));

  // {cs, lrst, fault[3:0], exp_auto, exp_latch, exp_trip, exp_bits[4:0]}
  localparam logic [13:0] VEC [10] = '{
    {1'b1, 1'b0, 4'b0000, 1'b1, 1'b0, 1'b0, 5'b00000},
    {1'b0, 1'b0, 4'b0000, 1'b1, 1'b0, 1'b0, 5'b00000},
    {1'b0, 1'b1, 4'b0000, 1'b1, 1'b1, 1'b0, 5'b00000},
    {1'b0, 1'b0, 4'b0110, 1'b0, 1'b0, 1'b1, 5'b00110},
    {1'b0, 1'b0, 4'b0110, 1'b0, 1'b0, 1'b0, 5'b00000},
    {1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, 1'b0, 5'b00000},
    {1'b1, 1'b0, 4'b0000, 1'b1, 1'b0, 1'b0, 5'b00000},
    {1'b0, 1'b1, 4'b0000, 1'b1, 1'b1, 1'b0, 5'b00000},
    {1'b0, 1'b0, 4'b1000, 1'b0, 1'b0, 1'b1, 5'b01000},
    {1'b0, 1'b1, 4'b1000, 1'b0, 1'b0, 1'b0, 5'b00000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One link tick: inputs set at a falling edge, tick high for one clock.
  task automatic step(input logic cs, input logic lr, input logic [N_IN-1:0] f);
    @(negedge clk);
    tick = 1'b1; cyc_start = cs; latch_rst = lr; fault_in = f;
    @(negedge clk);
    tick = 1'b0; cyc_start = 1'b0; latch_rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 permit_auto", permit_auto, 0);
    check("R9 permit_latch", permit_latch, 0);
    check("R9 first_valid", first_valid, 0);
    check("R9 trip_valid", trip_valid, 0);
    check("R9 hb_fault", hb_fault, 0);
    check("R9 active_mode", active_mode, 0);

    // Table walk: R3 trips, R5/R6 permits
    for (int k = 0; k < 10; k++) begin
      step(VEC[k][13], VEC[k][12], VEC[k][11:8]);
      check($sformatf("R5 auto step %0d", k), permit_auto, VEC[k][7]);
      check($sformatf("R6 latch step %0d", k), permit_latch, VEC[k][6]);
      check($sformatf("R3 trip_valid step %0d", k), trip_valid, VEC[k][5]);
      if (VEC[k][5]) check($sformatf("R3 trip_bits step %0d", k), trip_bits, VEC[k][4:0]);
      if (k == 3) check("R2 trip_stamp step 3", trip_stamp, 16'h0102);
    end
    check("R2 last trip_stamp", trip_stamp, 16'h0201);
    check("R4 first_valid", first_valid, 1);
    check("R4 first_idx lowest of pair", first_idx, 1);
    check("R4 first_stamp frozen", first_stamp, 16'h0102);

    // R4 clear then simultaneous new trips
    @(negedge clk); first_clear = 1'b1;
    @(negedge clk); first_clear = 1'b0;
    check("R4 cleared", first_valid, 0);
    step(1'b0, 1'b0, 4'b0101);
    check("R3 trip_bits pair", trip_bits, 5'b00101);
    check("R4 first_idx 0", first_idx, 0);
    check("R4 first_stamp", first_stamp, 16'h0203);

    // R1 fault levels only between ticks are ignored
    @(negedge clk); fault_in = 4'b1111;
    @(negedge clk); fault_in = 4'b0101;
    step(1'b0, 1'b0, 4'b0101);
    check("R1 no trip from off-tick pulse", trip_valid, 0);

    // R7 mask table and mode switch at cycle start
    @(negedge clk); mask_we = 1'b1; mask_addr = 3'd2; mask_wdata = 4'b1110;
    @(negedge clk); mask_we = 1'b0; mode_req = 3'd2;
    step(1'b0, 1'b0, 4'b0000);
    check("R7 mode held until cycle start", active_mode, 0);
    step(1'b1, 1'b0, 4'b0000);
    check("R7 mode switched", active_mode, 2);
    check("R5 auto rearmed", permit_auto, 1);
    step(1'b0, 1'b0, 4'b0001);
    check("R7 masked input no trip", trip_valid, 0);
    check("R7 masked input permit kept", permit_auto, 1);
    step(1'b0, 1'b0, 4'b0011);
    check("R7 enabled input trips", trip_bits, 5'b00010);
    check("R7 enabled input drops permit", permit_auto, 0);

    // R8 heartbeat watchdog
    step(1'b1, 1'b0, 4'b0000);
    check("R8 clean cycle start", permit_auto, 1);
    for (int k = 0; k < WDOG - 1; k++) step(1'b0, 1'b0, 4'b0000);
    check("R8 no fault before limit", hb_fault, 0);
    step(1'b0, 1'b0, 4'b0000);
    check("R8 fault at limit", hb_fault, 1);
    step(1'b0, 1'b0, 4'b0000);
    check("R8 trip on heartbeat bit", trip_valid, 1);
    check("R8 trip_bits heartbeat", trip_bits, 5'b10000);
    check("R8 permit dropped", permit_auto, 0);
    step(1'b1, 1'b0, 4'b0000);
    check("R8 cleared by cycle start", hb_fault, 0);
    check("R5 no rearm while fault sampled", permit_auto, 0);
    step(1'b1, 1'b0, 4'b0000);
    check("R5 rearm next cycle start", permit_auto, 1);
    check("R6 latch still low", permit_latch, 0);
    step(1'b0, 1'b1, 4'b0000);
    check("R6 latch rearm", permit_latch, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule